// File: doc/BRIEF.md
# Dual Serial Shift Register with Shared Input Select

The block holds two independent serial-in shift registers of eight stages each, 16 storage bits in all. Each register has its own pair of serial data inputs. A single select line, shared by both registers, picks which input of each pair feeds stage 0.

A register shifts once for every rising edge of its effective strobe. The effective strobe is the OR of a common strobe and that register's own strobe, so the two registers can be advanced together or one at a time. A strobe input that is not in use is held low.

All inputs are sampled on a free-running system clock, and the strobe inputs act as level signals whose rising edges are detected. Only the final stage of each register leaves the block, in true and inverted form. An active-low master clear acts at once, without waiting for a clock edge, and empties both registers.

Top module: `dual_shift_sel`

## Requirements
- R1: While `clr_n` is low, every stage of both lanes is 0, so `q_last` = 0 and `q_last_n` = all ones. This takes effect without a system clock edge.
- R2: Strobe edges that occur while `clr_n` is low are ignored. A strobe that is already high when `clr_n` is released does not cause a shift.
- R3: When `sel` = 0, a lane shifts in its `d0` bit. When `sel` = 1, it shifts in its `d1` bit. Lane i uses bit i of `d0` and bit i of `d1`, and `sel` applies to both lanes.
- R4: The effective strobe of lane i is `strb_common | strb_lane[i]`. A lane shifts at a system clock edge where its effective strobe is high and was low at the previous edge. A rising edge on one strobe input while the other input is already high is not an edge.
- R5: Each effective rising edge causes exactly one shift. Holding the strobe high, or leaving it low, leaves the stages unchanged.
- R6: On a shift, the selected bit enters stage 0, each stage moves one place toward stage DEPTH-1, and the old last stage is dropped. As a result, `q_last[i]` equals the bit that lane i took DEPTH (8) shifts earlier.
- R7: `q_last_n[i]` is always the inverse of `q_last[i]`.
- R8: A strobe on `strb_lane[i]` alone shifts only lane i. The other lane keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock; all inputs are sampled on its rising edge |
| clr_n | input | 1 | Asynchronous master clear, active low, common to both lanes |
| sel | input | 1 | Shared input select: 0 picks `d0`, 1 picks `d1` |
| d0 | input | LANES | Serial data input 0, one bit per lane |
| d1 | input | LANES | Serial data input 1, one bit per lane |
| strb_common | input | 1 | Shift strobe for both lanes, active high |
| strb_lane | input | LANES | Per-lane shift strobe, active high |
| q_last | output | LANES | Last stage of each lane |
| q_last_n | output | LANES | Inverse of the last stage of each lane |

## Verification
The first runs use the common strobe with `sel` fixed at 0 and then at 1, with random data on both input pairs. Because the unselected input carries different values, these runs show whether the wrong input is being taken. The next runs use one lane's strobe alone, which exposes any cross-coupling between the lanes. Random mixes of the common and lane strobes, with long stretches held high, show whether the block uses OR-combined edge detection or responds to levels. A clear asserted in mid-run, checked before the next clock edge and released with a strobe held high, shows whether the clear is asynchronous and whether a spurious shift occurs on release.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  typedef enum logic {
    PICK_D0 = 1'b0,
    PICK_D1 = 1'b1
  } pick_e;

  function automatic logic pick_bit(input pick_e s, input logic a, input logic b);
    return (s == PICK_D1) ? b : a;
  endfunction

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge (
  input  logic clk,
  input  logic clr_n,
  input  logic strb,
  output logic fire
);

  logic prev_q;

  // The history register is set to 1 during a clear, so a strobe that is
  // held high through the release of the clear is not seen as an edge.
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) prev_q <= 1'b1;
    else        prev_q <= strb;
  end

  assign fire = strb & ~prev_q;

  p_single_r5: assert property (@(posedge clk) disable iff (!clr_n)
    fire |=> !fire);

  p_level_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (strb && $past(strb)) |-> !fire);

endmodule

// File: rtl/shift_lane.sv
module shift_lane
  import dsr_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic clr_n,
  input  logic fire,
  input  logic sel,
  input  logic d0,
  input  logic d1,
  output logic q
);

  logic [DEPTH-1:0] stg_q;
  logic             nxt_bit;

  assign nxt_bit = pick_bit(pick_e'(sel), d0, d1);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)    stg_q <= '0;
    else if (fire) stg_q <= {stg_q[DEPTH-2:0], nxt_bit};
  end

  assign q = stg_q[DEPTH-1];

  p_take_r3: assert property (@(posedge clk) disable iff (!clr_n)
    fire |=> stg_q[0] == $past(sel ? d1 : d0));

  p_shift_r6: assert property (@(posedge clk) disable iff (!clr_n)
    fire |=> stg_q[DEPTH-1:1] == $past(stg_q[DEPTH-2:0]));

  p_hold_r5: assert property (@(posedge clk) disable iff (!clr_n)
    !fire |=> $stable(stg_q));

endmodule

// File: rtl/dual_shift_sel.sv
module dual_shift_sel #(
  parameter int LANES = 2,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             sel,
  input  logic [LANES-1:0] d0,
  input  logic [LANES-1:0] d1,
  input  logic             strb_common,
  input  logic [LANES-1:0] strb_lane,
  output logic [LANES-1:0] q_last,
  output logic [LANES-1:0] q_last_n
);

  logic [LANES-1:0] eff_strb;
  logic [LANES-1:0] fire;
  logic [LANES-1:0] last_bit;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign eff_strb[g] = strb_common | strb_lane[g];

    strobe_edge u_edge (
      .clk   (clk),
      .clr_n (clr_n),
      .strb  (eff_strb[g]),
      .fire  (fire[g])
    );

    shift_lane #(.DEPTH(DEPTH)) u_lane (
      .clk   (clk),
      .clr_n (clr_n),
      .fire  (fire[g]),
      .sel   (sel),
      .d0    (d0[g]),
      .d1    (d1[g]),
      .q     (last_bit[g])
    );
  end

  assign q_last   = last_bit;
  assign q_last_n = ~last_bit;

  p_clear_r1: assert property (@(posedge clk)
    !clr_n |-> (q_last == '0 && q_last_n == '1));

  p_lane_only_r8: assert property (@(posedge clk) disable iff (!clr_n)
    (fire == 2'b01) |=> $stable(q_last[1]));

endmodule

// File: tb/dual_shift_sel_tb.sv
module dual_shift_sel_tb_top;

  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       sel = 1'b0;
  logic [1:0] d0 = '0, d1 = '0;
  logic       strb_common = 1'b0;
  logic [1:0] strb_lane = '0;
  logic [1:0] q_last, q_last_n;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  bit mq0[$], mq1[$];
  bit prev0 = 1, prev1 = 1;

  always #4 clk = ~clk;

  dual_shift_sel #(.LANES(2), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .clr_n(clr_n), .sel(sel), .d0(d0), .d1(d1),
    .strb_common(strb_common), .strb_lane(strb_lane),
    .q_last(q_last), .q_last_n(q_last_n)
  );

  function automatic void model_clear();
    mq0 = {}; mq1 = {};
    for (int i = 0; i < DEPTH; i++) begin mq0.push_back(0); mq1.push_back(0); end
    prev0 = 1; prev1 = 1;
  endfunction

  function automatic void model_tick();
    bit s0, s1;
    if (!clr_n) begin model_clear(); return; end
    s0 = strb_common | strb_lane[0];
    s1 = strb_common | strb_lane[1];
    if (s0 && !prev0) begin mq0.push_front(sel ? d1[0] : d0[0]); void'(mq0.pop_back()); end
    if (s1 && !prev1) begin mq1.push_front(sel ? d1[1] : d0[1]); void'(mq1.pop_back()); end
    prev0 = s0; prev1 = s1;
  endfunction

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    logic [1:0] e;
    e = {mq1[DEPTH-1], mq0[DEPTH-1]};
    check(tag, q_last, e, "q_last");
    check("R7", q_last_n, ~e, "q_last_n");
  endtask

  task automatic step(string tag, bit c, bit [1:0] ls, bit s, bit [1:0] a, bit [1:0] b, bit cn);
    @(negedge clk);
    strb_common = c; strb_lane = ls; sel = s; d0 = a; d1 = b; clr_n = cn;
    @(posedge clk);
    model_tick();
    #1;
    compare(tag);
  endtask

  task automatic edges_common(string tag, bit s, int n);
    for (int k = 0; k < n; k++) begin
      bit [1:0] a, b;
      a = 2'($urandom); b = 2'($urandom);
      step(tag, 1, 2'b00, s, a, b, 1);
      step(tag, 0, 2'b00, s, a, b, 1);
    end
  endtask

  initial begin
    model_clear();
    // R1 and R2: clear held with strobes toggling.
    for (int k = 0; k < 6; k++) step("R2", k[0], {k[0], ~k[0]}, k[1], 2'b11, 2'b11, 0);
    #1 check("R1", q_last, 2'b00, "q_last during clear");
    check("R1", q_last_n, 2'b11, "q_last_n during clear");
    step("R2", 0, 2'b00, 0, 2'b00, 2'b00, 1);
    // R6: common strobe, sel=0.
    edges_common("R6", 0, 24);
    // R3: sel=1, then alternating sel.
    edges_common("R3", 1, 20);
    for (int k = 0; k < 10; k++) edges_common("R3", k[0], 1);
    // R8: one lane alone.
    for (int k = 0; k < 12; k++) begin
      bit [1:0] a = 2'($urandom);
      step("R8", 0, 2'b01, 0, a, ~a, 1);
      step("R8", 0, 2'b00, 0, a, ~a, 1);
    end
    for (int k = 0; k < 12; k++) begin
      bit [1:0] b = 2'($urandom);
      step("R8", 0, 2'b10, 1, ~b, b, 1);
      step("R8", 0, 2'b00, 1, ~b, b, 1);
    end
    // R4: random mixes of the strobe inputs, including overlaps.
    for (int k = 0; k < 200; k++)
      step("R4", 1'($urandom), 2'($urandom), 1'($urandom), 2'($urandom), 2'($urandom), 1);
    // R5: strobes held high over many clocks while the data changes.
    for (int k = 0; k < 10; k++) step("R5", 1, 2'b11, 1'($urandom), 2'($urandom), 2'($urandom), 1);
    for (int k = 0; k < 10; k++) step("R5", 0, 2'b00, 1'($urandom), 2'($urandom), 2'($urandom), 1);
    edges_common("R6", 1, 8);
    // R1: clear in mid-run, checked before any clock edge.
    @(negedge clk);
    clr_n = 0;
    #1;
    check("R1", q_last, 2'b00, "async clear q_last");
    check("R1", q_last_n, 2'b11, "async clear q_last_n");
    model_clear();
    step("R2", 1, 2'b11, 0, 2'b11, 2'b11, 0);
    // R2: release with the strobes already high gives no shift.
    step("R2", 1, 2'b11, 0, 2'b11, 2'b11, 1);
    step("R2", 1, 2'b11, 0, 2'b11, 2'b11, 1);
    for (int k = 0; k < 100; k++)
      step("R7", 1'($urandom), 2'($urandom), 1'($urandom), 2'($urandom), 2'($urandom), 1);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule